// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the speculative mapping from architectural register numbers to physical register tags in an out-of-order core. It keeps three renamed classes: integer, floating-point and condition-code. Each class has its own table and its own free-list pop port. A fourth class, used for miscellaneous registers, is hardwired. It is never renamed and always maps an index to the tag of the same value. Every request carries a 3-bit class code: 0 is integer, 1 is floating-point, 2 is condition-code and 3 is miscellaneous. Codes 4 to 7 are unknown.

A rename of a register returns two tags in the same cycle: the tag that is now assigned and the tag it displaces. The displaced tag is later freed by commit logic. A rename of a non-zero register in a renamed class takes the tag offered on that class's free-list port and pops it. The new tag is written into the table at the next rising clock edge.

The integer and floating-point classes each have a configurable zero register. That register is never reallocated. The condition-code class has none, which is set with a zero-index parameter of -1.

A combinational lookup port reads the current mapping. A set-entry port lets commit and squash logic overwrite a single entry.

Top module: `rename_table`

## Requirements
- R1: While `rst_ni` is low, entry i of each renamed class is set to tag i. After reset, `ren_ready_o` is 1, `fl_pop_o` is 0 and `err_o` is 0 while no request is made.
- R2: A valid rename of an in-range, non-zero index in class c, while `fl_avail_i[c]` is 1, does four things in the same cycle:
  - drives `fl_pop_o` to exactly bit c;
  - returns the slice `fl_tag_i[c*TAG_W +: TAG_W]` on `ren_new_o`;
  - returns the current entry on `ren_old_o`;
  - raises no error.

  From the next cycle on, that entry holds the new tag.
- R3: A rename of a class's zero register pops nothing, keeps `ren_ready_o` at 1 even with the free list empty, and returns the zero index on both `ren_new_o` and `ren_old_o`. The entry stays unchanged. Every in-range condition-code index is renamed normally.
- R4: While a valid non-zero rename is pending and its class's `fl_avail_i` bit is 0, three things hold:
  - `ren_ready_o` is 0;
  - `fl_pop_o` is 0;
  - the table is not written.
- R5: `lkp_tag_o` is a side-effect-free read of the entry at (`lkp_cls_i`, `lkp_idx_i`). It shows the value held before that cycle's writes. It is 0 for an unknown class or an out-of-range index.
- R6: A valid set-entry with an in-range index in a renamed class writes `set_tag_i` into that entry from the next cycle on.
- R7: When a rename and a set-entry hit the same entry in one cycle, the rename tag is stored. When they hit different entries, both writes take effect.
- R8: A rename in class 3 returns the index as both tags and pops nothing. A lookup in class 3 returns the index. A set-entry in class 3 that carries the index as its tag raises no error.
- R9: `err_o` rises in the same cycle, with no pop and no change to any table, for any of these requests:
  - a valid rename or set-entry with class code 4 to 7;
  - a valid rename or set-entry with an index at or beyond its class size;
  - a class-3 set-entry whose tag differs from its index.

  `ren_ready_o` stays 1 for an erroring rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ren_valid_i | input | 1 | Rename request valid |
| ren_cls_i | input | 3 | Rename class code |
| ren_idx_i | input | IDX_W | Rename architectural index |
| ren_ready_o | output | 1 | Rename accepted this cycle |
| ren_new_o | output | TAG_W | Newly assigned tag |
| ren_old_o | output | TAG_W | Displaced tag |
| fl_avail_i | input | 3 | Free-list non-empty, one bit per renamed class |
| fl_tag_i | input | 3*TAG_W | Free-list head tags, class c in slice c |
| fl_pop_o | output | 3 | Free-list pop, one bit per renamed class |
| set_valid_i | input | 1 | Set-entry valid |
| set_cls_i | input | 3 | Set-entry class code |
| set_idx_i | input | IDX_W | Set-entry index |
| set_tag_i | input | TAG_W | Tag to store |
| lkp_cls_i | input | 3 | Lookup class code |
| lkp_idx_i | input | IDX_W | Lookup index |
| lkp_tag_o | output | TAG_W | Current mapping |
| err_o | output | 1 | Illegal rename or set-entry request |

## Verification
The bench builds the block with four integer entries, four floating-point entries, three condition-code entries and two miscellaneous entries. Tags are 4 bits wide, the integer zero register is 0 and the floating-point zero register is 2. With the index narrowed to 2 bits, every entry of every class and every class code 0 to 7 can be swept. Each condition-code and miscellaneous index beyond its class size is reached, and the model of the tables is checked in full after every phase. The zero register sits at a different position in the integer and floating-point classes, so a zero check wired to the wrong class or position shows up.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    RC_INT  = 3'd0,
    RC_FP   = 3'd1,
    RC_CC   = 3'd2,
    RC_MISC = 3'd3
  } reg_cls_e;

  localparam int NUM_TBL = 3;
endpackage

// File: rtl/rn_class_table.sv
module rn_class_table #(
  parameter int N        = 32,
  parameter int TAG_W    = 7,
  parameter int IDX_W    = 5,
  parameter int ZERO_IDX = -1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_sel_i,
  input  logic [IDX_W-1:0] ren_idx_i,
  input  logic             avail_i,
  input  logic [TAG_W-1:0] fl_tag_i,
  output logic             pop_o,
  output logic             stall_o,
  output logic             ren_bad_o,
  output logic [TAG_W-1:0] ren_new_o,
  output logic [TAG_W-1:0] ren_old_o,
  input  logic             set_sel_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i,
  output logic             set_bad_o,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output logic [TAG_W-1:0] lkp_tag_o
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam logic [TAG_W-1:0] ZTAG = (ZERO_IDX >= 0) ? TAG_W'(ZERO_IDX) : '0;

  logic [TAG_W-1:0] tbl [N];

  logic          ren_in, set_in, lkp_in, is_zero, need;
  logic [AW-1:0] ren_a, set_a, lkp_a;

  assign ren_in  = int'(ren_idx_i) < N;
  assign set_in  = int'(set_idx_i) < N;
  assign lkp_in  = int'(lkp_idx_i) < N;
  assign ren_a   = ren_in ? ren_idx_i[AW-1:0] : '0;
  assign set_a   = set_in ? set_idx_i[AW-1:0] : '0;
  assign lkp_a   = lkp_in ? lkp_idx_i[AW-1:0] : '0;

  // class without a zero register uses a negative index that never matches
  assign is_zero = (ZERO_IDX >= 0) && (int'(ren_idx_i) == ZERO_IDX);
  assign need    = ren_sel_i && ren_in && !is_zero;

  assign pop_o     = need && avail_i;
  assign stall_o   = need && !avail_i;
  assign ren_bad_o = ren_sel_i && !ren_in;
  assign set_bad_o = set_sel_i && !set_in;

  always_comb begin
    if (is_zero) begin
      ren_new_o = ZTAG;
      ren_old_o = ZTAG;
    end else begin
      ren_new_o = fl_tag_i;
      ren_old_o = ren_in ? tbl[ren_a] : '0;
    end
  end

  assign lkp_tag_o = lkp_in ? tbl[lkp_a] : '0;

  // rename write is issued last so it wins over a set-entry to the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) tbl[i] <= TAG_W'(i);
    end else begin
      if (set_sel_i && set_in) tbl[set_a] <= set_tag_i;
      if (pop_o)               tbl[ren_a] <= fl_tag_i;
    end
  end
endmodule

// File: rtl/rn_misc_map.sv
module rn_misc_map #(
  parameter int N     = 8,
  parameter int TAG_W = 7,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] ren_idx_i,
  output logic [TAG_W-1:0] ren_tag_o,
  output logic             ren_bad_o,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i,
  output logic             set_bad_o,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output logic [TAG_W-1:0] lkp_tag_o
);
  logic ren_in, set_in, lkp_in;

  assign ren_in = int'(ren_idx_i) < N;
  assign set_in = int'(set_idx_i) < N;
  assign lkp_in = int'(lkp_idx_i) < N;

  // hardwired identity mapping
  assign ren_tag_o = ren_in ? TAG_W'(ren_idx_i) : '0;
  assign ren_bad_o = !ren_in;
  assign set_bad_o = !set_in || (set_tag_i != TAG_W'(set_idx_i));
  assign lkp_tag_o = lkp_in ? TAG_W'(lkp_idx_i) : '0;
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rn_pkg::*;
#(
  parameter int NUM_INT  = 32,
  parameter int NUM_FP   = 32,
  parameter int NUM_CC   = 5,
  parameter int NUM_MISC = 8,
  parameter int TAG_W    = 7,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 31,
  localparam int MAX_A01 = (NUM_INT > NUM_FP) ? NUM_INT : NUM_FP,
  localparam int MAX_A23 = (NUM_CC > NUM_MISC) ? NUM_CC : NUM_MISC,
  localparam int MAX_A   = (MAX_A01 > MAX_A23) ? MAX_A01 : MAX_A23,
  localparam int IDX_W   = (MAX_A > 1) ? $clog2(MAX_A) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ren_valid_i,
  input  logic [2:0]                 ren_cls_i,
  input  logic [IDX_W-1:0]           ren_idx_i,
  output logic                       ren_ready_o,
  output logic [TAG_W-1:0]           ren_new_o,
  output logic [TAG_W-1:0]           ren_old_o,
  input  logic [NUM_TBL-1:0]         fl_avail_i,
  input  logic [NUM_TBL*TAG_W-1:0]   fl_tag_i,
  output logic [NUM_TBL-1:0]         fl_pop_o,
  input  logic                       set_valid_i,
  input  logic [2:0]                 set_cls_i,
  input  logic [IDX_W-1:0]           set_idx_i,
  input  logic [TAG_W-1:0]           set_tag_i,
  input  logic [2:0]                 lkp_cls_i,
  input  logic [IDX_W-1:0]           lkp_idx_i,
  output logic [TAG_W-1:0]           lkp_tag_o,
  output logic                       err_o
);
  function automatic int tbl_n(int g);
    case (g)
      0:       return NUM_INT;
      1:       return NUM_FP;
      default: return NUM_CC;
    endcase
  endfunction

  function automatic int tbl_z(int g);
    case (g)
      0:       return INT_ZERO;
      1:       return FP_ZERO;
      default: return -1;
    endcase
  endfunction

  logic [NUM_TBL-1:0] t_stall, t_ren_bad, t_set_bad;
  logic [TAG_W-1:0]   t_new [NUM_TBL];
  logic [TAG_W-1:0]   t_old [NUM_TBL];
  logic [TAG_W-1:0]   t_lkp [NUM_TBL];

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    rn_class_table #(
      .N        (tbl_n(g)),
      .TAG_W    (TAG_W),
      .IDX_W    (IDX_W),
      .ZERO_IDX (tbl_z(g))
    ) u_tbl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ren_sel_i (ren_valid_i && (ren_cls_i == 3'(g))),
      .ren_idx_i (ren_idx_i),
      .avail_i   (fl_avail_i[g]),
      .fl_tag_i  (fl_tag_i[g*TAG_W +: TAG_W]),
      .pop_o     (fl_pop_o[g]),
      .stall_o   (t_stall[g]),
      .ren_bad_o (t_ren_bad[g]),
      .ren_new_o (t_new[g]),
      .ren_old_o (t_old[g]),
      .set_sel_i (set_valid_i && (set_cls_i == 3'(g))),
      .set_idx_i (set_idx_i),
      .set_tag_i (set_tag_i),
      .set_bad_o (t_set_bad[g]),
      .lkp_idx_i (lkp_idx_i),
      .lkp_tag_o (t_lkp[g])
    );
  end

  logic [TAG_W-1:0] m_ren_tag, m_lkp_tag;
  logic             m_ren_bad, m_set_bad;

  rn_misc_map #(
    .N     (NUM_MISC),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_misc (
    .ren_idx_i (ren_idx_i),
    .ren_tag_o (m_ren_tag),
    .ren_bad_o (m_ren_bad),
    .set_idx_i (set_idx_i),
    .set_tag_i (set_tag_i),
    .set_bad_o (m_set_bad),
    .lkp_idx_i (lkp_idx_i),
    .lkp_tag_o (m_lkp_tag)
  );

  logic ren_err, set_err;

  always_comb begin
    ren_new_o = '0;
    ren_old_o = '0;
    ren_err   = 1'b0;
    case (ren_cls_i)
      RC_INT, RC_FP, RC_CC: begin
        ren_new_o = t_new[ren_cls_i[1:0]];
        ren_old_o = t_old[ren_cls_i[1:0]];
        ren_err   = t_ren_bad[ren_cls_i[1:0]];
      end
      RC_MISC: begin
        ren_new_o = m_ren_tag;
        ren_old_o = m_ren_tag;
        ren_err   = ren_valid_i && m_ren_bad;
      end
      default: ren_err = ren_valid_i;
    endcase
  end

  always_comb begin
    case (set_cls_i)
      RC_INT, RC_FP, RC_CC: set_err = t_set_bad[set_cls_i[1:0]];
      RC_MISC:              set_err = set_valid_i && m_set_bad;
      default:              set_err = set_valid_i;
    endcase
  end

  always_comb begin
    case (lkp_cls_i)
      RC_INT, RC_FP, RC_CC: lkp_tag_o = t_lkp[lkp_cls_i[1:0]];
      RC_MISC:              lkp_tag_o = m_lkp_tag;
      default:              lkp_tag_o = '0;
    endcase
  end

  assign ren_ready_o = ~|t_stall;
  assign err_o       = ren_err || set_err;
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk #(
  parameter int NUM_INT  = 32,
  parameter int NUM_MISC = 8,
  parameter int TAG_W    = 7,
  parameter int INT_ZERO = 0,
  parameter int IDX_W    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ren_valid_i,
  input logic [2:0]         ren_cls_i,
  input logic [IDX_W-1:0]   ren_idx_i,
  input logic               ren_ready_o,
  input logic [TAG_W-1:0]   ren_new_o,
  input logic [TAG_W-1:0]   ren_old_o,
  input logic [3*TAG_W-1:0] fl_tag_i,
  input logic [2:0]         fl_pop_o,
  input logic               set_valid_i,
  input logic [2:0]         set_cls_i,
  input logic [IDX_W-1:0]   set_idx_i,
  input logic [TAG_W-1:0]   set_tag_i,
  input logic [2:0]         lkp_cls_i,
  input logic [IDX_W-1:0]   lkp_idx_i,
  input logic [TAG_W-1:0]   lkp_tag_o,
  input logic               err_o
);
  assert_pop_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fl_pop_o));

  assert_pop_tag_int_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_pop_o[0] |-> ren_valid_i && ren_ready_o && ren_new_o == fl_tag_i[0 +: TAG_W]);

  assert_pop_tag_fp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_pop_o[1] |-> ren_valid_i && ren_ready_o && ren_new_o == fl_tag_i[TAG_W +: TAG_W]);

  assert_pop_tag_cc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_pop_o[2] |-> ren_valid_i && ren_ready_o && ren_new_o == fl_tag_i[2*TAG_W +: TAG_W]);

  assert_zero_reg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_cls_i == 3'd0 && int'(ren_idx_i) == INT_ZERO)
      |-> fl_pop_o == 3'b000 && ren_ready_o
          && ren_new_o == TAG_W'(INT_ZERO) && ren_old_o == TAG_W'(INT_ZERO));

  assert_stall_no_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && !ren_ready_o) |-> fl_pop_o == 3'b000);

  assert_lookup_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(set_valid_i) && $past(fl_pop_o) == 3'b000
     && $stable(lkp_cls_i) && $stable(lkp_idx_i)) |-> $stable(lkp_tag_o));

  assert_set_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(set_valid_i) && $past(set_cls_i) == 3'd0
     && $past(fl_pop_o) == 3'b000 && int'($past(set_idx_i)) < NUM_INT
     && lkp_cls_i == 3'd0 && lkp_idx_i == $past(set_idx_i))
      |-> lkp_tag_o == $past(set_tag_i));

  assert_misc_identity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_cls_i == 3'd3 && int'(ren_idx_i) < NUM_MISC)
      |-> fl_pop_o == 3'b000 && ren_new_o == TAG_W'(ren_idx_i) && ren_old_o == TAG_W'(ren_idx_i));

  assert_bad_class_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_cls_i[2]) |-> err_o && fl_pop_o == 3'b000 && ren_ready_o);
endmodule

bind rename_table rename_table_chk #(
  .NUM_INT  (NUM_INT),
  .NUM_MISC (NUM_MISC),
  .TAG_W    (TAG_W),
  .INT_ZERO (INT_ZERO),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ren_valid_i (ren_valid_i),
  .ren_cls_i   (ren_cls_i),
  .ren_idx_i   (ren_idx_i),
  .ren_ready_o (ren_ready_o),
  .ren_new_o   (ren_new_o),
  .ren_old_o   (ren_old_o),
  .fl_tag_i    (fl_tag_i),
  .fl_pop_o    (fl_pop_o),
  .set_valid_i (set_valid_i),
  .set_cls_i   (set_cls_i),
  .set_idx_i   (set_idx_i),
  .set_tag_i   (set_tag_i),
  .lkp_cls_i   (lkp_cls_i),
  .lkp_idx_i   (lkp_idx_i),
  .lkp_tag_o   (lkp_tag_o),
  .err_o       (err_o)
);

// File: tb/rename_table_tb.sv
module rename_table_tb;
  localparam int NI = 4, NF = 4, NC = 3, NM = 2, TW = 4, IZ = 0, FZ = 2, IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          ren_valid_i;
  logic [2:0]    ren_cls_i;
  logic [IW-1:0] ren_idx_i;
  logic          ren_ready_o;
  logic [TW-1:0] ren_new_o, ren_old_o;
  logic [2:0]    fl_avail_i;
  logic [3*TW-1:0] fl_tag_i;
  logic [2:0]    fl_pop_o;
  logic          set_valid_i;
  logic [2:0]    set_cls_i;
  logic [IW-1:0] set_idx_i;
  logic [TW-1:0] set_tag_i;
  logic [2:0]    lkp_cls_i;
  logic [IW-1:0] lkp_idx_i;
  logic [TW-1:0] lkp_tag_o;
  logic          err_o;

  always #10 clk_i = ~clk_i;

  rename_table #(
    .NUM_INT (NI), .NUM_FP (NF), .NUM_CC (NC), .NUM_MISC (NM),
    .TAG_W (TW), .INT_ZERO (IZ), .FP_ZERO (FZ)
  ) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int mdl [3][4];
  int seq = 0;
  bit done = 0;

  function automatic int num_of(int c);
    case (c)
      0: return NI; 1: return NF; 2: return NC; 3: return NM;
      default: return 0;
    endcase
  endfunction

  function automatic int zero_of(int c);
    case (c)
      0: return IZ; 1: return FZ;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_lkp(int c, int i);
    if (i >= num_of(c)) return 0;
    if (c == 3) return i;
    return mdl[c][i];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid_i = 0; ren_cls_i = 0; ren_idx_i = 0;
    set_valid_i = 0; set_cls_i = 0; set_idx_i = 0; set_tag_i = 0;
    lkp_cls_i = 0; lkp_idx_i = 0;
    fl_avail_i = 3'b111; fl_tag_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // free-list heads: distinct tag per class slice
  task automatic load_tags(output int s0, output int s1, output int s2);
    seq++;
    s0 = (seq * 5 + 3) % 16;
    s1 = (s0 + 6) % 16;
    s2 = (s0 + 11) % 16;
    fl_tag_i = {TW'(s2), TW'(s1), TW'(s0)};
  endtask

  task automatic sweep_lookups(string req);
    for (int c = 0; c < 5; c++)
      for (int i = 0; i < 4; i++) begin
        lkp_cls_i = 3'(c); lkp_idx_i = IW'(i);
        #1;
        chk(req, $sformatf("lookup c%0d i%0d", c, i), int'(lkp_tag_o), exp_lkp(c, i));
      end
    lkp_cls_i = 0; lkp_idx_i = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s [3];
    idle();
    rst_ni = 0;
    for (int c = 0; c < 3; c++) for (int i = 0; i < 4; i++) mdl[c][i] = i;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1: reset state
    #1;
    chk("R1", "ready", int'(ren_ready_o), 1);
    chk("R1", "pop", int'(fl_pop_o), 0);
    chk("R1", "err", int'(err_o), 0);
    sweep_lookups("R1");
    @(negedge clk_i);

    // R2/R3/R5: rename sweep over every entry of the renamed classes, twice
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 3; c++)
        for (int i = 0; i < num_of(c); i++) begin
          bit z;
          idle();
          load_tags(s[0], s[1], s[2]);
          ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = IW'(i);
          lkp_cls_i = 3'(c); lkp_idx_i = IW'(i);
          z = (i == zero_of(c));
          #5;
          chk("R2", "ready", int'(ren_ready_o), 1);
          chk(z ? "R3" : "R2", "pop", int'(fl_pop_o), z ? 0 : (1 << c));
          chk(z ? "R3" : "R2", "new", int'(ren_new_o), z ? i : s[c]);
          chk(z ? "R3" : "R2", "old", int'(ren_old_o), z ? i : mdl[c][i]);
          chk("R2", "err", int'(err_o), 0);
          chk("R5", "pre-write lookup", int'(lkp_tag_o), mdl[c][i]);
          tick();
          if (!z) mdl[c][i] = s[c];
          idle();
          lkp_cls_i = 3'(c); lkp_idx_i = IW'(i);
          #1;
          chk(z ? "R3" : "R2", "entry after", int'(lkp_tag_o), mdl[c][i]);
        end
    idle();
    sweep_lookups("R2");
    @(negedge clk_i);

    // R4: stall on empty free list; R3: zero register ignores it
    for (int c = 0; c < 3; c++) begin
      idle();
      load_tags(s[0], s[1], s[2]);
      fl_avail_i = ~(3'b001 << c);
      ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = 1;
      #5;
      chk("R4", "ready", int'(ren_ready_o), 0);
      chk("R4", "pop", int'(fl_pop_o), 0);
      chk("R4", "err", int'(err_o), 0);
      tick();
      idle();
      lkp_cls_i = 3'(c); lkp_idx_i = 1;
      #1;
      chk("R4", "entry unchanged", int'(lkp_tag_o), mdl[c][1]);
    end
    idle();
    fl_avail_i = 3'b000;
    ren_valid_i = 1; ren_cls_i = 0; ren_idx_i = IW'(IZ);
    #5;
    chk("R3", "zero ready empty fl", int'(ren_ready_o), 1);
    chk("R3", "zero no pop", int'(fl_pop_o), 0);
    ren_cls_i = 1; ren_idx_i = IW'(FZ);
    #1;
    chk("R3", "fp zero ready empty fl", int'(ren_ready_o), 1);
    tick();
    idle();
    sweep_lookups("R4");
    @(negedge clk_i);

    // R6/R5: set-entry sweep
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < num_of(c); i++) begin
        int t;
        idle();
        t = (c * 4 + i + 7) % 16;
        set_valid_i = 1; set_cls_i = 3'(c); set_idx_i = IW'(i); set_tag_i = TW'(t);
        lkp_cls_i = 3'(c); lkp_idx_i = IW'(i);
        #5;
        chk("R5", "lookup before set", int'(lkp_tag_o), mdl[c][i]);
        chk("R6", "err", int'(err_o), 0);
        tick();
        mdl[c][i] = t;
        idle();
        lkp_cls_i = 3'(c); lkp_idx_i = IW'(i);
        #1;
        chk("R6", "entry after set", int'(lkp_tag_o), t);
      end
    idle();
    @(negedge clk_i);

    // R7: rename and set-entry in the same cycle
    for (int c = 0; c < 3; c++) begin
      idle();
      load_tags(s[0], s[1], s[2]);
      ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = 1;
      set_valid_i = 1; set_cls_i = 3'(c); set_idx_i = 1; set_tag_i = TW'((s[c] + 1) % 16);
      #5;
      chk("R7", "pop", int'(fl_pop_o), 1 << c);
      tick();
      mdl[c][1] = s[c];
      idle();
      lkp_cls_i = 3'(c); lkp_idx_i = 1;
      #1;
      chk("R7", "rename wins", int'(lkp_tag_o), s[c]);
      @(negedge clk_i);
      idle();
      load_tags(s[0], s[1], s[2]);
      ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = 1;
      set_valid_i = 1; set_cls_i = 3'(c); set_idx_i = 0; set_tag_i = TW'((s[c] + 2) % 16);
      tick();
      mdl[c][1] = s[c];
      mdl[c][0] = (s[c] + 2) % 16;
      idle();
      lkp_cls_i = 3'(c); lkp_idx_i = 1;
      #1;
      chk("R7", "rename other entry", int'(lkp_tag_o), mdl[c][1]);
      lkp_idx_i = 0;
      #1;
      chk("R7", "set other entry", int'(lkp_tag_o), mdl[c][0]);
      @(negedge clk_i);
    end

    // R8/R9: miscellaneous class
    for (int i = 0; i < NM; i++) begin
      idle();
      load_tags(s[0], s[1], s[2]);
      ren_valid_i = 1; ren_cls_i = 3; ren_idx_i = IW'(i);
      #5;
      chk("R8", "misc new", int'(ren_new_o), i);
      chk("R8", "misc old", int'(ren_old_o), i);
      chk("R8", "misc pop", int'(fl_pop_o), 0);
      chk("R8", "misc ready", int'(ren_ready_o), 1);
      chk("R8", "misc err", int'(err_o), 0);
      tick();
      idle();
      set_valid_i = 1; set_cls_i = 3; set_idx_i = IW'(i); set_tag_i = TW'(i);
      #5;
      chk("R8", "misc set same tag err", int'(err_o), 0);
      set_tag_i = TW'(i + 1);
      #1;
      chk("R9", "misc set other tag err", int'(err_o), 1);
      tick();
    end
    idle();
    sweep_lookups("R8");
    @(negedge clk_i);

    // R9: unknown class codes and out-of-range indices
    for (int c = 4; c < 8; c++) begin
      idle();
      load_tags(s[0], s[1], s[2]);
      ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = 1;
      #5;
      chk("R9", "bad class ren err", int'(err_o), 1);
      chk("R9", "bad class pop", int'(fl_pop_o), 0);
      chk("R9", "bad class ready", int'(ren_ready_o), 1);
      tick();
      idle();
      set_valid_i = 1; set_cls_i = 3'(c); set_idx_i = 1; set_tag_i = 4'hF;
      #5;
      chk("R9", "bad class set err", int'(err_o), 1);
      tick();
    end
    for (int c = 2; c < 4; c++)
      for (int i = num_of(c); i < 4; i++) begin
        idle();
        load_tags(s[0], s[1], s[2]);
        ren_valid_i = 1; ren_cls_i = 3'(c); ren_idx_i = IW'(i);
        #5;
        chk("R9", "range ren err", int'(err_o), 1);
        chk("R9", "range pop", int'(fl_pop_o), 0);
        tick();
        idle();
        set_valid_i = 1; set_cls_i = 3'(c); set_idx_i = IW'(i); set_tag_i = TW'(i);
        #5;
        chk("R9", "range set err", int'(err_o), 1);
        tick();
      end
    idle();
    #5;
    chk("R9", "err clear idle", int'(err_o), 0);
    sweep_lookups("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule